// File: doc/BRIEF.md
# I2C bus hang recovery sequencer

This block sits beside an I2C master controller and guards each transfer with a watchdog. A transfer begins when the transfer-active flag rises while the block is idle. If the flag is still high when the programmed timeout runs out, the block samples the controller's status flags and decides whether the bus looks wedged. When it does, the block writes the status back with the arbitration-lost flag cleared and then drives a train of clock pulses on SCL through open-drain enables. The aim is to let a slave that is holding SDA finish its byte and let go of the bus. Every timeout ends in a one-cycle I/O-error pulse, whether or not recovery ran.

The pulse timing comes from the real configured bus frequency. A short serial divider turns that frequency into a base delay in microseconds, and nine clock cycles follow, each with a low time of one base delay and a high time of two. If the frequency is given as zero, the block runs a fixed five-step sequence in its place, with every step held for 30 µs. All delays are counted on a one-microsecond tick input. The block also drives a three-bit control word that copies the enable, start and transmit settings the controller would take in each step. Transfer requests that arrive while a recovery is running are ignored.

Top module: `i2c_hang_recover`

## Requirements
- R1: After a transfer starts, `io_err` pulses for one cycle once the transfer has stayed active for limit × TICK_US microsecond ticks, where limit = `timeout_us` / TICK_US in integer division.
- R2: The limit never falls below MIN_TICKS (default 5) scheduler ticks. A `timeout_us` of zero selects DEFAULT_TIMEOUT_US (default one second).
- R3: If the transfer-active flag drops before the limit is reached, the watchdog is cancelled and no error is reported. The next rising edge starts a fresh full-length count.
- R4: At timeout, recovery starts when any of status bit 0 (complete), bit 1 (bus busy) or bit 2 (no-acknowledge) is set. Bit 3 (arbitration lost) set on its own does not start recovery.
- R5: As recovery starts, `sr_wr` pulses for one cycle with `sr_wdata` equal to `stat` with bit 3 cleared. No write-back happens when there is no recovery.
- R6: For a non-zero `bus_hz`, the base delay is 1,000,000 / `bus_hz` + 1 microseconds (integer division), raised to 2 if it comes out smaller.
- R7: The clocked recovery runs exactly 9 cycles. Each cycle is `mctl` = 3'b000 (bit 0 enable, bit 1 transmit, bit 2 start) for at least one clock, then 3'b111 for one base delay, then 3'b001 for twice the base delay.
- R8: When `bus_hz` is zero, the block runs five steps of 30 µs each, with `mctl` = 000, 001, 110, 111 and 001 in that order.
- R9: `scl_oe` is high exactly while `mctl` = 3'b111. `sda_oe` is high only in the 3'b111 step of the fallback sequence. Both lines are released in reset, while idle and once recovery ends.
- R10: In the cycle after the last delay of a recovery runs out, `io_err` and `rec_done` pulse together for one cycle. A timeout without recovery pulses `io_err` alone.
- R11: `busy` is high for the whole recovery. Rising edges of the transfer-active flag during recovery are ignored and do not arm the watchdog.
- R12: After reset, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| us_tick | input | 1 | One-cycle strobe once per microsecond |
| xfer_active | input | 1 | High while the controller runs a transfer |
| stat | input | 4 | Controller flags: bit 0 complete, bit 1 bus busy, bit 2 no-acknowledge, bit 3 arbitration lost |
| timeout_us | input | TMO_W | Transfer timeout in microseconds; zero selects the default |
| bus_hz | input | HZ_W | Real configured bus frequency in Hz; zero means unknown |
| scl_oe | output | 1 | Pull SCL low when high |
| sda_oe | output | 1 | Pull SDA low when high |
| mctl | output | 3 | Controller setting for the current step: bit 0 enable, bit 1 transmit, bit 2 start |
| sr_wr | output | 1 | One-cycle status write-back strobe |
| sr_wdata | output | 4 | Status value to write back |
| busy | output | 1 | Recovery in progress |
| io_err | output | 1 | One-cycle I/O-error pulse after a timeout |
| rec_done | output | 1 | One-cycle pulse when a recovery finishes |

## Verification
The bound checker watches the invariants that hold in every cycle: both lines released whenever no recovery is running, SDA pulled only while SCL is also pulled, a write-back that never carries the arbitration-lost bit and only comes during recovery, and single-cycle completion and error pulses that line up with the end of `busy`. Other properties can only be shown by the bench's scenarios. These are the microsecond counts of the watchdog limit, its floor and its default, the base delay worked out for several bus frequencies including the minimum clamp, the count of nine pulses, the order and length of the fallback steps, and the fact that a transfer started during recovery has no effect.

// File: rtl/hr_pkg.sv
package hr_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_WATCH,
      ST_CALC,
      ST_OFF,
      ST_PULSE,
      ST_REL,
      ST_FB
   } hr_state_e;

   // control word bits: [0] enable, [1] transmit, [2] start
   localparam logic [2:0] CTL_OFF   = 3'b000;
   localparam logic [2:0] CTL_EN    = 3'b001;
   localparam logic [2:0] CTL_ST_TX = 3'b110;
   localparam logic [2:0] CTL_ALL   = 3'b111;

   // status bit positions shared with the controller
   localparam int SB_DONE = 0;
   localparam int SB_BUSY = 1;
   localparam int SB_NACK = 2;
   localparam int SB_ARB  = 3;

   localparam int FB_STEPS = 5;

   function automatic logic [2:0] fb_ctl(input logic [2:0] step);
      case (step)
         3'd0:    fb_ctl = CTL_OFF;
         3'd1:    fb_ctl = CTL_EN;
         3'd2:    fb_ctl = CTL_ST_TX;
         3'd3:    fb_ctl = CTL_ALL;
         3'd4:    fb_ctl = CTL_EN;
         default: fb_ctl = CTL_OFF;
      endcase
   endfunction

endpackage

// File: rtl/hr_watchdog.sv
module hr_watchdog #(
   parameter int TICK_US = 1000,
   parameter int LIM_W   = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             run,
   input  logic             us_tick,
   input  logic [LIM_W-1:0] limit,
   output logic             expire
);
   localparam int PRE_W = (TICK_US > 1) ? $clog2(TICK_US) : 1;

   logic [LIM_W-1:0] cnt, lim_q;
   logic             last_pre;

   generate
      if (TICK_US > 1) begin : g_prescale
         logic [PRE_W-1:0] pre;
         assign last_pre = (pre == PRE_W'(TICK_US - 1));
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                pre <= '0;
            else if (start)            pre <= '0;
            else if (run && us_tick)   pre <= last_pre ? '0 : pre + 1'b1;
         end
      end else begin : g_direct
         assign last_pre = 1'b1;
      end
   endgenerate

   assign expire = run && us_tick && last_pre && (cnt == lim_q - 1'b1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt   <= '0;
         lim_q <= '0;
      end else if (start) begin
         cnt   <= '0;
         lim_q <= limit;
      end else if (run && us_tick && last_pre) begin
         cnt <= cnt + 1'b1;
      end
   end
endmodule

// File: rtl/hr_udiv.sv
module hr_udiv #(
   parameter int N_W = 20,
   parameter int D_W = 20
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           start,
   input  logic [N_W-1:0] num,
   input  logic [D_W-1:0] den,
   output logic           done,
   output logic [N_W-1:0] quo
);
   localparam int C_W = $clog2(N_W + 1);

   logic [D_W-1:0] rem, den_q;
   logic [C_W-1:0] cnt;
   logic           run;
   logic [D_W:0]   trial, diff;
   logic           ge;

   always_comb begin
      trial = {rem, quo[N_W-1]};
      ge    = (trial >= {1'b0, den_q});
      diff  = trial - {1'b0, den_q};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rem   <= '0;
         den_q <= '0;
         quo   <= '0;
         cnt   <= '0;
         run   <= 1'b0;
         done  <= 1'b0;
      end else begin
         done <= 1'b0;
         if (start) begin
            rem   <= '0;
            quo   <= num;
            den_q <= den;
            cnt   <= C_W'(N_W);
            run   <= 1'b1;
         end else if (run) begin
            rem <= ge ? diff[D_W-1:0] : trial[D_W-1:0];
            quo <= {quo[N_W-2:0], ge};
            cnt <= cnt - 1'b1;
            if (cnt == C_W'(1)) begin
               run  <= 1'b0;
               done <= 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/hr_hold.sv
module hr_hold #(
   parameter int W = 22
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] val,
   input  logic         us_tick,
   output logic         expire
);
   logic [W-1:0] cnt;
   logic         run;

   assign expire = run && us_tick && (cnt == W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
         run <= 1'b0;
      end else if (load) begin
         cnt <= val;
         run <= 1'b1;
      end else if (run && us_tick) begin
         cnt <= cnt - 1'b1;
         if (cnt == W'(1)) run <= 1'b0;
      end
   end
endmodule

// File: rtl/i2c_hang_recover.sv
module i2c_hang_recover #(
   parameter int TICK_US            = 1000,
   parameter int DEFAULT_TIMEOUT_US = 1_000_000,
   parameter int MIN_TICKS          = 5,
   parameter int TMO_W              = 32,
   parameter int HZ_W               = 20,
   parameter int NUM_PULSES         = 9,
   parameter int FB_STEP_US         = 30
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             us_tick,
   input  logic             xfer_active,
   input  logic [3:0]       stat,
   input  logic [TMO_W-1:0] timeout_us,
   input  logic [HZ_W-1:0]  bus_hz,
   output logic             scl_oe,
   output logic             sda_oe,
   output logic [2:0]       mctl,
   output logic             sr_wr,
   output logic [3:0]       sr_wdata,
   output logic             busy,
   output logic             io_err,
   output logic             rec_done
);
   import hr_pkg::*;

   localparam int USEC_PER_S = 1_000_000;
   localparam int NUM_W      = $clog2(USEC_PER_S + 1);
   localparam int DLY_W      = NUM_W + 1;
   localparam int HOLD_W     = DLY_W + 1;
   localparam int PC_W       = $clog2(NUM_PULSES + 1);

   generate
      if (TICK_US < 1) begin : g_bad_tick
         $error("TICK_US must be at least 1");
      end
      if (MIN_TICKS < 1) begin : g_bad_min
         $error("MIN_TICKS must be at least 1");
      end
      if (NUM_PULSES < 1) begin : g_bad_pulses
         $error("NUM_PULSES must be at least 1");
      end
      if (HZ_W > 31 || HZ_W < 2) begin : g_bad_hz
         $error("HZ_W out of range");
      end
      if (FB_STEP_US < 1 || FB_STEP_US >= (1 << HOLD_W)) begin : g_bad_fb
         $error("FB_STEP_US does not fit the hold timer");
      end
   endgenerate

   hr_state_e        st, st_n;
   logic             xa_q, xfer_start, hang;
   logic [TMO_W-1:0] tmo_sel, lim_raw, lim_val;
   logic             wd_expire, hold_expire, hold_ld, div_go, div_done;
   logic [HOLD_W-1:0] hold_val;
   logic [NUM_W-1:0] quo;
   logic [DLY_W-1:0] base_q, base_sum, base_calc;
   logic [PC_W-1:0]  cyc;
   logic [2:0]       fb_step;

   // ---------------- watchdog limit ----------------
   always_comb begin
      tmo_sel = (timeout_us == '0) ? TMO_W'(DEFAULT_TIMEOUT_US) : timeout_us;
      lim_raw = tmo_sel / TMO_W'(TICK_US);
      lim_val = (lim_raw < TMO_W'(MIN_TICKS)) ? TMO_W'(MIN_TICKS) : lim_raw;
   end

   assign xfer_start = xfer_active && !xa_q && (st == ST_IDLE);
   assign hang       = stat[SB_DONE] | stat[SB_BUSY] | stat[SB_NACK];

   hr_watchdog #(.TICK_US(TICK_US), .LIM_W(TMO_W)) u_wdog (
      .clk(clk), .rst_n(rst_n), .start(xfer_start),
      .run(st == ST_WATCH), .us_tick(us_tick),
      .limit(lim_val), .expire(wd_expire)
   );

   hr_udiv #(.N_W(NUM_W), .D_W(HZ_W)) u_div (
      .clk(clk), .rst_n(rst_n), .start(div_go),
      .num(NUM_W'(USEC_PER_S)), .den(bus_hz),
      .done(div_done), .quo(quo)
   );

   hr_hold #(.W(HOLD_W)) u_hold (
      .clk(clk), .rst_n(rst_n), .load(hold_ld), .val(hold_val),
      .us_tick(us_tick), .expire(hold_expire)
   );

   // ---------------- base delay ----------------
   always_comb begin
      base_sum  = DLY_W'(quo) + DLY_W'(1);
      base_calc = (base_sum < DLY_W'(2)) ? DLY_W'(2) : base_sum;
   end

   // ---------------- sequencer ----------------
   always_comb begin
      st_n     = st;
      hold_ld  = 1'b0;
      hold_val = '0;
      div_go   = 1'b0;
      unique case (st)
         ST_IDLE: if (xfer_start) st_n = ST_WATCH;
         ST_WATCH: begin
            if (!xfer_active) begin
               st_n = ST_IDLE;
            end else if (wd_expire) begin
               if (!hang) begin
                  st_n = ST_IDLE;
               end else if (bus_hz != '0) begin
                  st_n   = ST_CALC;
                  div_go = 1'b1;
               end else begin
                  st_n     = ST_FB;
                  hold_ld  = 1'b1;
                  hold_val = HOLD_W'(FB_STEP_US);
               end
            end
         end
         ST_CALC: if (div_done) st_n = ST_OFF;
         ST_OFF: begin
            st_n     = ST_PULSE;
            hold_ld  = 1'b1;
            hold_val = HOLD_W'(base_q);
         end
         ST_PULSE: begin
            if (hold_expire) begin
               st_n     = ST_REL;
               hold_ld  = 1'b1;
               hold_val = {base_q, 1'b0};
            end
         end
         ST_REL: begin
            if (hold_expire)
               st_n = (cyc == PC_W'(NUM_PULSES - 1)) ? ST_IDLE : ST_OFF;
         end
         ST_FB: begin
            if (hold_expire) begin
               if (fb_step == 3'(FB_STEPS - 1)) begin
                  st_n = ST_IDLE;
               end else begin
                  hold_ld  = 1'b1;
                  hold_val = HOLD_W'(FB_STEP_US);
               end
            end
         end
         default: st_n = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= ST_IDLE;
         xa_q     <= 1'b0;
         io_err   <= 1'b0;
         rec_done <= 1'b0;
         sr_wr    <= 1'b0;
         sr_wdata <= '0;
         base_q   <= DLY_W'(2);
         cyc      <= '0;
         fb_step  <= '0;
      end else begin
         st       <= st_n;
         xa_q     <= xfer_active;
         io_err   <= 1'b0;
         rec_done <= 1'b0;
         sr_wr    <= 1'b0;
         if (st == ST_WATCH && xfer_active && wd_expire) begin
            io_err  <= !hang;
            cyc     <= '0;
            fb_step <= '0;
            if (hang) begin
               sr_wr    <= 1'b1;
               sr_wdata <= stat & ~(4'b0001 << SB_ARB);
            end
         end
         if (st == ST_CALC && div_done) base_q <= base_calc;
         if (st == ST_REL && hold_expire) begin
            if (cyc == PC_W'(NUM_PULSES - 1)) begin
               io_err   <= 1'b1;
               rec_done <= 1'b1;
            end else begin
               cyc <= cyc + 1'b1;
            end
         end
         if (st == ST_FB && hold_expire) begin
            if (fb_step == 3'(FB_STEPS - 1)) begin
               io_err   <= 1'b1;
               rec_done <= 1'b1;
            end else begin
               fb_step <= fb_step + 1'b1;
            end
         end
      end
   end

   // ---------------- outputs ----------------
   always_comb begin
      unique case (st)
         ST_PULSE: mctl = CTL_ALL;
         ST_REL:   mctl = CTL_EN;
         ST_FB:    mctl = fb_ctl(fb_step);
         default:  mctl = CTL_OFF;
      endcase
   end

   assign scl_oe = (mctl == CTL_ALL);
   assign sda_oe = (st == ST_FB) && (mctl == CTL_ALL);
   assign busy   = (st != ST_IDLE) && (st != ST_WATCH);

endmodule

// File: rtl/i2c_hang_recover_chk.sv
module i2c_hang_recover_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       scl_oe,
   input logic       sda_oe,
   input logic [2:0] mctl,
   input logic       sr_wr,
   input logic [3:0] sr_wdata,
   input logic       busy,
   input logic       io_err,
   input logic       rec_done
);
   assert_idle_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!scl_oe && !sda_oe && mctl == 3'b000));

   assert_sda_with_scl_R9: assert property (@(posedge clk) disable iff (!rst_n)
      sda_oe |-> scl_oe);

   assert_writeback_clean_R5: assert property (@(posedge clk) disable iff (!rst_n)
      sr_wr |-> (!sr_wdata[3] && (|sr_wdata[2:0]) && busy));

   assert_done_has_err_R10: assert property (@(posedge clk) disable iff (!rst_n)
      rec_done |-> io_err);

   assert_err_one_cycle_R10: assert property (@(posedge clk) disable iff (!rst_n)
      io_err |=> !io_err);

   assert_done_ends_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
      rec_done |-> (!busy && $past(busy)));
endmodule

bind i2c_hang_recover i2c_hang_recover_chk u_chk (
   .clk(clk), .rst_n(rst_n), .scl_oe(scl_oe), .sda_oe(sda_oe), .mctl(mctl),
   .sr_wr(sr_wr), .sr_wdata(sr_wdata), .busy(busy), .io_err(io_err),
   .rec_done(rec_done)
);

// File: tb/i2c_hang_recover_test.sv
`timescale 1ns/1ps
module i2c_hang_recover_test;
   localparam int CLK_PERIOD = 10;
   localparam int TICK_US    = 4;
   localparam int DEF_US     = 60;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        us_tick = 1'b0;
   logic        xfer_active = 1'b0;
   logic [3:0]  stat = '0;
   logic [31:0] timeout_us = '0;
   logic [19:0] bus_hz = '0;
   logic        scl_oe, sda_oe, sr_wr, busy, io_err, rec_done;
   logic [2:0]  mctl;
   logic [3:0]  sr_wdata;

   int n_chk = 0;
   int n_fail = 0;
   int tdiv = 0;

   logic [2:0] rv [0:39];
   int         rc [0:39];
   bit         rs [0:39];
   int         nr;

   i2c_hang_recover #(.TICK_US(TICK_US), .DEFAULT_TIMEOUT_US(DEF_US)) uut (
      .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .xfer_active(xfer_active),
      .stat(stat), .timeout_us(timeout_us), .bus_hz(bus_hz),
      .scl_oe(scl_oe), .sda_oe(sda_oe), .mctl(mctl), .sr_wr(sr_wr),
      .sr_wdata(sr_wdata), .busy(busy), .io_err(io_err), .rec_done(rec_done)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   // microsecond strobe: one clock in three, changed just after the edge
   always @(posedge clk) begin
      #1;
      tdiv    = (tdiv == 2) ? 0 : tdiv + 1;
      us_tick = (tdiv == 2);
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      xfer_active = 1'b0;
      repeat (3) @(negedge clk);
      chk({scl_oe, sda_oe, sr_wr, busy, io_err, rec_done, mctl} == '0,
          "R12", "outputs in reset", {scl_oe, sda_oe, busy, io_err, mctl}, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk({scl_oe, sda_oe, sr_wr, busy, io_err, rec_done, mctl} == '0,
          "R12", "outputs after reset", {scl_oe, sda_oe, busy, io_err, mctl}, 0);
   endtask

   // timeout without a hang flag: count ticks to io_err
   task automatic timeout_case(input int tmo, input int exp_ticks, input string req);
      int  cnt = 0;
      int  guard = 0;
      bit  bad = 0;
      timeout_us = tmo;
      stat = 4'b1000;
      @(negedge clk);
      xfer_active = 1'b1;
      @(posedge clk);
      while (guard < 20000) begin
         @(negedge clk);
         guard++;
         if (io_err) break;
         if (busy || sr_wr || rec_done) bad = 1;
         if (us_tick) cnt++;
      end
      chk(io_err == 1'b1 && cnt == exp_ticks, req, "ticks to timeout", cnt, exp_ticks);
      chk(!bad && !rec_done, "R4", "arbitration-lost alone starts no recovery", bad, 0);
      @(negedge clk);
      chk(!io_err, "R10", "io_err width one cycle", io_err, 0);
      xfer_active = 1'b0;
      repeat (2) @(negedge clk);
   endtask

   // transfer ends early: no error; restart reloads full count
   task automatic early_end_case();
      int  cnt = 0;
      bit  err_seen = 0;
      timeout_us = 40;
      stat = 4'b0010;
      @(negedge clk);
      xfer_active = 1'b1;
      @(posedge clk);
      while (cnt < 30) begin
         @(negedge clk);
         if (us_tick) cnt++;
      end
      xfer_active = 1'b0;
      repeat (300) begin
         @(negedge clk);
         if (io_err || busy) err_seen = 1;
      end
      chk(!err_seen, "R3", "no error after early end", err_seen, 0);
      timeout_case(40, 40, "R3 reload");
   endtask

   task automatic rec_case(input logic [19:0] hz, input logic [3:0] st,
                           input bit fb, input int base, input bit poke,
                           input string req);
      int        guard = 0;
      int        wb_seen = 0;
      logic [3:0] wb_val = '0;
      int        poked = 0;
      int        bad_v = 0, bad_p = 0, bad_r = 0, bad_s = 0;
      bit        late = 0;
      bus_hz = hz;
      stat = st;
      timeout_us = 20;
      nr = 0;
      @(negedge clk);
      xfer_active = 1'b1;
      while (guard < 20000) begin
         @(negedge clk);
         guard++;
         if (io_err) break;
         if (sr_wr) begin
            wb_seen++;
            wb_val = sr_wdata;
         end
         if (busy && nr < 40) begin
            if (nr == 0 || mctl != rv[nr-1]) begin
               rv[nr] = mctl;
               rc[nr] = us_tick ? 1 : 0;
               rs[nr] = sda_oe;
               nr++;
            end else begin
               if (us_tick) rc[nr-1]++;
               if (sda_oe) rs[nr-1] = 1'b1;
            end
         end
         if (poke && poked == 1) begin
            xfer_active = 1'b1;
            poked = 2;
         end else if (poke && poked == 0 && nr == 2) begin
            xfer_active = 1'b0;
            poked = 1;
         end
      end
      chk(rec_done && io_err, "R10", "done and error pulse together", rec_done, 1);
      chk(!busy && !scl_oe && !sda_oe, "R9", "lines released at end",
          {busy, scl_oe, sda_oe}, 0);
      chk(wb_seen == 1 && wb_val == (st & 4'b0111), "R5", "status write-back",
          wb_val, st & 4'b0111);
      if (!fb) begin
         chk(nr == 27, "R7", "number of control runs (9 cycles)", nr, 27);
         for (int k = 0; k < 9 && 3*k+2 < nr; k++) begin
            if (rv[3*k] != 3'b000 || rv[3*k+1] != 3'b111 || rv[3*k+2] != 3'b001) bad_v++;
            if (rc[3*k+1] != base) bad_p++;
            if (rc[3*k+2] != 2*base) bad_r++;
            if (rs[3*k+1] || rs[3*k+2]) bad_s++;
         end
         chk(bad_v == 0, "R7", "control word order", bad_v, 0);
         chk(bad_p == 0, req, "low time equals base delay", rc[1], base);
         chk(bad_r == 0, "R7", "release time twice base", rc[2], 2*base);
         chk(bad_s == 0, "R9", "SDA untouched in clocked mode", bad_s, 0);
      end else begin
         chk(nr == 5, "R8", "fallback step count", nr, 5);
         if (nr == 5) begin
            chk(rv[0] == 3'b000 && rv[1] == 3'b001 && rv[2] == 3'b110 &&
                rv[3] == 3'b111 && rv[4] == 3'b001, "R8", "fallback order",
                {rv[0], rv[1], rv[2], rv[3], rv[4]}, 15'b000_001_110_111_001);
            for (int k = 0; k < 5; k++)
               if (rc[k] != 30) bad_p++;
            chk(bad_p == 0, "R8", "each fallback step 30 us", rc[0], 30);
            chk(!rs[0] && !rs[1] && !rs[2] && rs[3] && !rs[4], "R9",
                "SDA only in start step", {rs[0], rs[1], rs[2], rs[3], rs[4]}, 5'b00010);
         end
      end
      @(negedge clk);
      chk(!io_err && !rec_done, "R10", "completion pulses one cycle", io_err, 0);
      if (poke) begin
         repeat (200) begin
            @(negedge clk);
            if (io_err || busy || sr_wr) late = 1;
         end
         chk(!late, "R11", "transfer started during recovery ignored", late, 0);
      end
      xfer_active = 1'b0;
      repeat (3) @(negedge clk);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      do_reset();
      timeout_case(40, 40, "R1");
      timeout_case(8, 20, "R2 floor");
      timeout_case(0, 60, "R2 default");
      early_end_case();
      rec_case(20'd375000, 4'b1010, 1'b0, 3, 1'b0, "R6 375kHz busy-only R4");
      rec_case(20'd1000000, 4'b1001, 1'b0, 2, 1'b0, "R6 1MHz");
      rec_case(20'd1048575, 4'b0100, 1'b0, 2, 1'b0, "R6 minimum clamp");
      rec_case(20'd100000, 4'b0011, 1'b0, 11, 1'b0, "R6 100kHz");
      rec_case(20'd0, 4'b1111, 1'b1, 0, 1'b1, "R8");
      do_reset();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule